// File: doc/BRIEF.md
# ECC Partial-Write Read-Modify-Write Engine

This block sits between a write requester and an SRAM whose words carry SECDED check bits over a whole chunk of `DATA_W` bits (32 or 64, chosen at build time). A write whose byte strobes are all set is encoded and sent to the SRAM in the cycle it is accepted. A narrower write made while ECC checking is enabled becomes a read-modify-write. The block reads the full chunk, checks and corrects it, merges in the strobed bytes, re-encodes the result and writes the whole chunk back.

When checking is disabled, a narrow write goes straight to the SRAM with its byte enables. Its check bits are still computed, but only from the partial word given, so they are knowingly wrong for the stored chunk. The SRAM answers a read one cycle after the request. Each accepted write returns a single response pulse. The pulse flags a corrected single-bit error or an uncorrectable double-bit error found by the internal read.

Top module: `ecc_rmw_engine`

## Requirements
- R1: A write with all strobes set is accepted while `wr_ready_o` is high. In that same cycle it drives one SRAM write with `mem_we_o`=1, all byte enables set, the requester's data and check bits encoded from that data. `resp_valid_o` pulses in the next cycle with both error flags low.
- R2: When `ecc_en_i` is low at acceptance, a write with some strobes clear goes straight through in the accept cycle. It carries `mem_be_o` equal to `wr_strb_i` and check bits encoded from the unmerged `wr_data_i`. Its response follows one cycle later with no error flags.
- R3: When `ecc_en_i` is high at acceptance and some strobes are clear, the accept cycle issues an SRAM read (`mem_we_o`=0) to the write address. `wr_ready_o` is low for the next cycle (check) and the one after (write-back), and no SRAM request is made in the check cycle. The write-back goes to the same address. `ecc_en_i` only matters in the accept cycle.
- R4: The write-back data takes, for byte lane k (bits 8k+7..8k), the new byte where strobe bit k is set and the corrected old byte where it is clear. All byte enables are set.
- R5: Check bits use a Hamming code. Data bit j sits at the j-th codeword position, counting up from 1 and skipping powers of two. Check bit k (k below the top bit) is the XOR of the data bits whose position has bit k set. The top check bit is the XOR of all data bits and all other check bits. Every SRAM write, in every mode, carries the check bits of the data it drives.
- R6: A single-bit error in the internal read, in a data bit or a check bit, is corrected before the merge. The response two cycles after the check cycle carries `resp_sgl_o`=1 and `resp_dbl_o`=0.
- R7: A double-bit error in the internal read abandons the write. No SRAM write is made, `resp_valid_o` and `resp_dbl_o` pulse in the cycle after the check cycle, and `wr_ready_o` is high again in that same cycle.
- R8: After reset `wr_ready_o` is high and `resp_valid_o` and `mem_req_o` are low.
- R9: A `wr_valid_i` held while `wr_ready_o` is low has no effect. It causes no SRAM request and does not change the write-back data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ecc_en_i | input | 1 | ECC checking enable, sampled at write acceptance |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Engine can accept a write this cycle |
| wr_addr_i | input | ADDR_W | Chunk address |
| wr_data_i | input | DATA_W | Write data |
| wr_strb_i | input | DATA_W/8 | Byte strobes |
| resp_valid_o | output | 1 | One-cycle completion pulse |
| resp_sgl_o | output | 1 | Corrected single-bit error seen on the internal read |
| resp_dbl_o | output | 1 | Uncorrectable error, write abandoned |
| mem_req_o | output | 1 | SRAM request |
| mem_we_o | output | 1 | SRAM write (1) or read (0) |
| mem_addr_o | output | ADDR_W | SRAM address |
| mem_be_o | output | DATA_W/8 | SRAM byte enables for data |
| mem_wdata_o | output | DATA_W | SRAM write data |
| mem_wchk_o | output | CHK_W | SRAM write check bits, always written |
| mem_rdata_i | input | DATA_W | SRAM read data, one cycle after a read request |
| mem_rchk_i | input | CHK_W | SRAM read check bits, same timing |

## Verification
The SRAM-side request of a direct write, or the read of a read-modify-write, is due in the accept cycle itself. The bench samples it one time step after driving the inputs, before the clock edge. A direct write's response is due one edge later. A double-error response is due two edges after acceptance, while the write-back and its check bits come at the same point for the other case, and the response with the single-error flag follows at three edges. The bench steps exactly that many falling edges per phase and samples each result there. It also compares its own SRAM model after every operation, so a stray write or a wrong byte enable shows up in memory contents as well as at the ports.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CHECK = 2'd1,
    S_WRITE = 2'd2
  } rmw_state_e;

  // number of Hamming check bits (without the overall parity bit)
  function automatic int ham_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  // codeword position of data bit j: positions from 1, skipping powers of two
  function automatic int data_pos(input int j);
    int cnt;
    int res;
    cnt = -1;
    res = 0;
    for (int q = 1; q < 256; q++) begin
      if ((q & (q - 1)) != 0) begin
        cnt++;
        if (cnt == j && res == 0) res = q;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc #(
  parameter int DATA_W = 32,
  parameter int CHK_W  = ecc_rmw_pkg::ham_bits(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  localparam int HAM_W = CHK_W - 1;

  logic [HAM_W-1:0] ham;

  always_comb begin
    ham = '0;
    for (int j = 0; j < DATA_W; j++) begin
      for (int k = 0; k < HAM_W; k++) begin
        if (((ecc_rmw_pkg::data_pos(j) >> k) & 1) != 0) ham[k] = ham[k] ^ data_i[j];
      end
    end
  end

  assign chk_o = {(^data_i) ^ (^ham), ham};

endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec #(
  parameter int DATA_W = 32,
  parameter int CHK_W  = ecc_rmw_pkg::ham_bits(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sgl_o,
  output logic              dbl_o
);
  localparam int HAM_W = CHK_W - 1;

  logic [CHK_W-1:0] recalc;
  logic [HAM_W-1:0] syn;
  logic             par;

  ecc_secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
    .data_i (data_i),
    .chk_o  (recalc)
  );

  assign syn = chk_i[HAM_W-1:0] ^ recalc[HAM_W-1:0];
  assign par = (^data_i) ^ (^chk_i);

  // odd overall parity: one flip (syndrome 0 means the parity bit itself)
  assign sgl_o = par;
  assign dbl_o = !par && (syn != '0);

  for (genvar j = 0; j < DATA_W; j++) begin : g_fix
    localparam int POS = ecc_rmw_pkg::data_pos(j);
    assign data_o[j] = data_i[j] ^ (par && (syn == HAM_W'(POS)));
  end

endmodule

// File: rtl/ecc_byte_merge.sv
module ecc_byte_merge #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic [BYTES-1:0]  strb_i,
  output logic [DATA_W-1:0] data_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign data_o[8*b +: 8] = strb_i[b] ? new_i[8*b +: 8] : old_i[8*b +: 8];
  end
endmodule

// File: rtl/ecc_rmw_engine.sv
module ecc_rmw_engine #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  localparam int BYTES = DATA_W / 8,
  localparam int CHK_W = ecc_rmw_pkg::ham_bits(DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ecc_en_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [BYTES-1:0]  wr_strb_i,
  output logic              resp_valid_o,
  output logic              resp_sgl_o,
  output logic              resp_dbl_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [CHK_W-1:0]  mem_wchk_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [CHK_W-1:0]  mem_rchk_i
);
  import ecc_rmw_pkg::*;

  rmw_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, merged_q, merged_d, fixed;
  logic [BYTES-1:0]  strb_q;
  logic              sgl_q, dec_sgl, dec_dbl;
  logic              accept, full, rmw;
  logic              resp_valid_q, resp_sgl_q, resp_dbl_q;

  assign wr_ready_o = (state_q == S_IDLE);
  assign accept     = wr_valid_i && wr_ready_o;
  assign full       = &wr_strb_i;
  assign rmw        = ecc_en_i && !full;

  ecc_secded_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
    .data_i (mem_rdata_i),
    .chk_i  (mem_rchk_i),
    .data_o (fixed),
    .sgl_o  (dec_sgl),
    .dbl_o  (dec_dbl)
  );

  ecc_byte_merge #(.DATA_W(DATA_W)) u_merge (
    .old_i  (fixed),
    .new_i  (data_q),
    .strb_i (strb_q),
    .data_o (merged_d)
  );

  ecc_secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
    .data_i (mem_wdata_o),
    .chk_o  (mem_wchk_o)
  );

  // SRAM request mux
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = addr_q;
    mem_be_o    = '1;
    mem_wdata_o = merged_q;
    if (state_q == S_IDLE && accept) begin
      mem_req_o   = 1'b1;
      mem_we_o    = !rmw;
      mem_addr_o  = wr_addr_i;
      mem_be_o    = wr_strb_i;
      mem_wdata_o = wr_data_i;
    end else if (state_q == S_WRITE) begin
      mem_req_o = 1'b1;
      mem_we_o  = 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (accept && rmw) state_d = S_CHECK;
      S_CHECK: state_d = dec_dbl ? S_IDLE : S_WRITE;
      S_WRITE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      addr_q       <= '0;
      data_q       <= '0;
      strb_q       <= '0;
      merged_q     <= '0;
      sgl_q        <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_sgl_q   <= 1'b0;
      resp_dbl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept && rmw) begin
        addr_q <= wr_addr_i;
        data_q <= wr_data_i;
        strb_q <= wr_strb_i;
      end
      if (state_q == S_CHECK) begin
        merged_q <= merged_d;
        sgl_q    <= dec_sgl;
      end
      resp_valid_q <= (accept && !rmw) || (state_q == S_CHECK && dec_dbl) || (state_q == S_WRITE);
      resp_dbl_q   <= (state_q == S_CHECK) && dec_dbl;
      resp_sgl_q   <= (state_q == S_WRITE) && sgl_q;
    end
  end

  assign resp_valid_o = resp_valid_q;
  assign resp_sgl_o   = resp_sgl_q;
  assign resp_dbl_o   = resp_dbl_q;

  a_r1_direct_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !rmw) |=> (resp_valid_o && !resp_sgl_o && !resp_dbl_o && wr_ready_o));

  a_r3_busy_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && rmw) |=> (!wr_ready_o && !mem_req_o));

  a_r3_wb_same_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !wr_ready_o) |-> (mem_addr_o == $past(mem_addr_o, 2) && &mem_be_o));

  a_r7_dbl_abandon: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CHECK && dec_dbl) |=> (!mem_req_o && resp_valid_o && resp_dbl_o && wr_ready_o));

  a_r6_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({resp_sgl_o, resp_dbl_o}) && ((resp_sgl_o || resp_dbl_o) -> resp_valid_o));

  a_r9_no_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> !mem_req_o);

endmodule

// File: tb/ecc_rmw_engine_tb.sv
module ecc_rmw_engine_tb;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int NB = DW / 8;
  localparam int CW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          ecc_en, wr_valid, wr_ready;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [NB-1:0] wr_strb;
  logic          resp_valid, resp_sgl, resp_dbl;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [NB-1:0] mem_be;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [CW-1:0] mem_wchk, mem_rchk;

  ecc_rmw_engine #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ecc_en_i(ecc_en),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_strb_i(wr_strb),
    .resp_valid_o(resp_valid), .resp_sgl_o(resp_sgl), .resp_dbl_o(resp_dbl),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_wchk_o(mem_wchk),
    .mem_rdata_i(mem_rdata), .mem_rchk_i(mem_rchk)
  );

  // SRAM model, one-cycle read latency, read errors injected by mask
  logic [DW-1:0] sram_d [16];
  logic [CW-1:0] sram_c [16];
  logic [DW-1:0] inj_d;
  logic [CW-1:0] inj_c;
  logic [DW-1:0] exp_d [16];
  logic [CW-1:0] exp_c [16];

  always_ff @(posedge clk) begin
    if (mem_req && !mem_we) begin
      mem_rdata <= sram_d[mem_addr] ^ inj_d;
      mem_rchk  <= sram_c[mem_addr] ^ inj_c;
    end
    if (mem_req && mem_we) begin
      for (int b = 0; b < NB; b++)
        if (mem_be[b]) sram_d[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
      sram_c[mem_addr] <= mem_wchk;
    end
  end

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R5 code: Hamming positions skipping powers of two, top bit overall parity
  function automatic logic [CW-1:0] enc(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int pos;
    c = '0;
    pos = 1;
    for (int j = 0; j < DW; j++) begin
      while ((pos & (pos - 1)) == 0) pos++;
      for (int k = 0; k < CW - 1; k++)
        if ((pos >> k) & 1) c[k] = c[k] ^ d[j];
      pos++;
    end
    c[CW-1] = (^d) ^ (^c[CW-2:0]);
    return c;
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n, input logic [NB-1:0] s);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++) r[8*b +: 8] = s[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  // inj: 0 none, 1 single data bit, 2 single check bit, 3 double data bits
  task automatic do_write(input int a, input logic [DW-1:0] d, input logic [NB-1:0] s,
                          input bit en, input int inj, input int seed, input bit garb);
    bit rmw;
    logic [DW-1:0] m;
    rmw = en && (s != '1);
    m = merge(exp_d[a], d, s);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = AW'(a); wr_data = d; wr_strb = s; ecc_en = en;
    inj_d = '0; inj_c = '0;
    if (inj == 1) inj_d[(seed * 5) % DW] = 1'b1;
    if (inj == 2) inj_c[seed % CW] = 1'b1;
    if (inj == 3) begin
      inj_d[seed % DW] = 1'b1;
      inj_d[(seed + 9) % DW] = 1'b1;
    end
    #1;
    check(wr_ready == 1'b1, "R1 ready at accept", 64'(wr_ready), 64'd1);
    check(mem_req && mem_addr == AW'(a), "R3 accept-cycle request", 64'(mem_addr), 64'(a));
    check(mem_we == !rmw, "R3 read versus write", 64'(mem_we), 64'(!rmw));
    if (!rmw) begin
      check(mem_be == s, "R2 byte enables", 64'(mem_be), 64'(s));
      check(mem_wdata == d, "R1 write data", 64'(mem_wdata), 64'(d));
      check(mem_wchk == enc(d), "R5 check bits direct", 64'(mem_wchk), 64'(enc(d)));
      @(negedge clk);
      wr_valid = 1'b0;
      check(resp_valid && !resp_sgl && !resp_dbl, "R2 direct response", 64'({resp_valid, resp_sgl, resp_dbl}), 64'b100);
      check(wr_ready == 1'b1, "R1 ready after direct", 64'(wr_ready), 64'd1);
      exp_d[a] = merge(exp_d[a], d, s);
      exp_c[a] = enc(d);
    end else begin
      @(negedge clk);
      wr_valid = 1'b0;
      check(wr_ready == 1'b0 && !resp_valid, "R3 busy in check", 64'({wr_ready, resp_valid}), 64'd0);
      if (garb) begin
        wr_valid = 1'b1; wr_data = ~d; wr_strb = '1; ecc_en = 1'b0; wr_addr = AW'(a + 1);
      end
      #1;
      check(mem_req == 1'b0, "R9 no request while busy", 64'(mem_req), 64'd0);
      @(negedge clk);
      wr_valid = 1'b0;
      if (inj == 3) begin
        check(resp_valid && resp_dbl && !resp_sgl, "R7 double flagged", 64'({resp_valid, resp_sgl, resp_dbl}), 64'b101);
        check(wr_ready == 1'b1 && mem_req == 1'b0, "R7 abandoned, ready", 64'({wr_ready, mem_req}), 64'b10);
      end else begin
        check(wr_ready == 1'b0 && mem_req && mem_we, "R3 write-back", 64'({wr_ready, mem_req, mem_we}), 64'b011);
        check(mem_addr == AW'(a) && mem_be == '1, "R4 full enables same addr", 64'({mem_addr, mem_be}), 64'({AW'(a), NB'('1)}));
        check(mem_wdata == m, "R4 merged data", 64'(mem_wdata), 64'(m));
        check(mem_wchk == enc(m), "R5 check bits merged", 64'(mem_wchk), 64'(enc(m)));
        @(negedge clk);
        check(resp_valid && !resp_dbl && (resp_sgl == (inj == 1 || inj == 2)), "R6 response flags",
              64'({resp_valid, resp_sgl, resp_dbl}), 64'({1'b1, (inj == 1 || inj == 2), 1'b0}));
        check(wr_ready == 1'b1, "R3 ready after write-back", 64'(wr_ready), 64'd1);
        exp_d[a] = m;
        exp_c[a] = enc(m);
      end
    end
    inj_d = '0; inj_c = '0;
    check(sram_d[a] == exp_d[a] && sram_c[a] == exp_c[a], "R4 stored word",
          64'({sram_c[a], sram_d[a]}), 64'({exp_c[a], exp_d[a]}));
  endtask

  task automatic fill_all();
    for (int a = 0; a < 16; a++) do_write(a, 32'h9E37_79B9 * (a + 3), '1, 1'b1, 0, a, 1'b0);
  endtask

  initial begin
    ecc_en = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; wr_strb = '0;
    inj_d = '0; inj_c = '0; mem_rdata = '0; mem_rchk = '0;
    for (int a = 0; a < 16; a++) begin
      sram_d[a] = '0; sram_c[a] = '0; exp_d[a] = '0; exp_c[a] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    check(wr_ready == 1'b1 && !resp_valid && !mem_req, "R8 reset state",
          64'({wr_ready, resp_valid, mem_req}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(wr_ready == 1'b1 && !resp_valid && !mem_req, "R8 after reset release",
          64'({wr_ready, resp_valid, mem_req}), 64'b100);
    fill_all();
    // narrow writes with checking off: straight through, partial check bits
    for (int s = 0; s < 16; s++) do_write(s, 32'h1234_5678 ^ (32'h0101_0101 * s), NB'(s), 1'b0, 0, s, 1'b0);
    fill_all();
    // every strobe pattern through read-modify-write, error kinds rotated
    for (int s = 0; s < 16; s++) do_write(s, 32'hA5C3_0F96 + 32'h1357_9BDF * s, NB'(s), 1'b1, s % 4, s + 2, (s % 4) != 3);
    for (int s = 0; s < 16; s++) do_write(15 - s, 32'h0F1E_2D3C * (s + 1), NB'(s), 1'b1, (s + 1) % 4, s * 3 + 1, 1'b0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule